// File: doc/BRIEF.md
# Cascadable Thirty-Two Source Interrupt Controller

The block gathers thirty-two interrupt request lines per controller unit, latches each request into a sticky status word and gates that word with a software-owned enable word. Any surviving request raises a single interrupt line towards the processor. A priority vector names the lowest-numbered pending source, so software can find the next source without scanning the status word.

One primary unit and up to two auxiliary units live inside the top module. Each auxiliary unit's interrupt line is ORed into a fixed input of the primary as a level request: the first auxiliary into source 30 and the second into source 28. A single register port serves all units. Address bits [3:2] select the unit and bits [1:0] select a register within it. Writes take effect at the next rising clock edge, and reads are combinational from the registered state.

Each unit's output stage is a two-state machine. `ST_QUIET` moves to `ST_RAISED` on the edge where the masked status is nonzero. `ST_RAISED` returns to `ST_QUIET` on the edge where the masked status is zero. In every other case the machine stays where it is. The interrupt line is high only in `ST_RAISED`.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, every status and enable word is zero, `irq_out` is low, and the vector (port and register) reads 255.
- R2: A high level on source n at a rising edge sets status bit (31 - n), so source 0 is bit 31. The bit stays set after the line falls, until software clears it.
- R3: Writing the status register (register index 0) clears each bit written as one and leaves bits written as zero unchanged. If the source is still high at that edge, the bit stays set.
- R4: The enable register (index 1) reads back what was written. The masked register (index 2) reads status AND enable. Writes to index 2 or index 3 change nothing.
- R5: The vector (index 3, bits [7:0], upper bits zero, and port `irq_vec` for the primary) equals the number of leading zeros of the masked status, which is the lowest pending enabled source number. It is 255 when nothing masked is pending.
- R6: `irq_out` rises one edge after the primary masked status becomes nonzero. It falls one edge after the masked status becomes zero through a clear or a mask.
- R7: Auxiliary unit 1's interrupt line is a level request on primary source 30 (bit 1), and auxiliary unit 2's is a level request on primary source 28 (bit 3). While the auxiliary line is high, clearing that primary bit has no effect.
- R8: A register write made at one edge is visible to a read in the following cycle.
- R9: Address bits [3:2] select the unit: 0 is the primary, 1 is auxiliary 1, 2 is auxiliary 2. Unit 3 reads as zero. A write to one unit leaves the other units' registers untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | [3:2] unit select, [1:0] register index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_addr` |
| src_main | input | 32 | Primary request lines, bit n is source n |
| src_aux1 | input | 32 | Auxiliary unit 1 request lines |
| src_aux2 | input | 32 | Auxiliary unit 2 request lines |
| irq_out | output | 1 | Interrupt line to the processor |
| irq_vec | output | 8 | Primary priority vector, 255 when idle |

## Verification
The hardest condition to reach from the ports is a primary status bit that cannot be cleared because its cascaded request is still alive. That request is fed by a state register in another unit, two edges away from the auxiliary input. The stimulus enables a source in an auxiliary unit, pulses it, and waits until the primary latches the cascaded bit. It then writes a clear to the primary while the auxiliary status is still pending. The bench checks that the bit survives. It then clears the auxiliary unit first and shows that the primary bit can now be removed. A second hard corner is two cascaded requests pending together, where the vector must pick source 28 over source 30.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IRQC_NSRC = 32;
    localparam int IRQC_VW   = 8;
    localparam logic [IRQC_VW-1:0] IRQC_VEC_NONE = 8'hFF;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_MASKED = 2'd2,
        REG_VECTOR = 2'd3
    } irqc_reg_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irqc_state_e;
endpackage

// File: rtl/irqc_prio.sv
// Leading-zero priority encoder: the highest set bit wins, reported as its
// distance from the MSB; all-zero input gives the idle code.
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int W  = IRQC_NSRC,
    parameter int VW = IRQC_VW
) (
    input  logic [W-1:0]  bits,
    output logic [VW-1:0] idx
);
    always_comb begin
        idx = IRQC_VEC_NONE;
        // ascending scan: a later (more significant) hit overrides
        for (int i = 0; i < W; i++) begin
            if (bits[i]) idx = VW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/irqc_unit.sv
// One controller unit: sticky status, enable word, masked view, vector and
// a two-state output machine.
module irqc_unit
    import irqc_pkg::*;
#(
    parameter int NSRC = IRQC_NSRC,
    parameter int VW   = IRQC_VW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_wr,
    input  logic            en_wr,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] lines,
    output logic [NSRC-1:0] stat_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] masked,
    output logic [VW-1:0]   vec,
    output logic            irq
);
    logic [NSRC-1:0] req_bits;
    logic [NSRC-1:0] clr_bits;
    logic [NSRC-1:0] stat_d;
    irqc_state_e     state_q, state_d;

    // source n lands on register bit NSRC-1-n
    for (genvar n = 0; n < NSRC; n++) begin : g_map
        assign req_bits[NSRC-1-n] = lines[n];
    end

    assign clr_bits = stat_wr ? wdata : '0;
    assign stat_d   = (stat_q & ~clr_bits) | req_bits;
    assign masked   = stat_q & en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (en_wr) en_q <= wdata;
        end
    end

    irqc_prio #(.W(NSRC), .VW(VW)) u_prio (
        .bits (masked),
        .idx  (vec)
    );

    // output machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (|masked)  state_d = ST_RAISED;
            ST_RAISED: if (!(|masked)) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    // output machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // output machine: outputs
    always_comb begin
        unique case (state_q)
            ST_RAISED: irq = 1'b1;
            default:   irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqc_cascade.sv
// Primary unit plus AUX_COUNT auxiliary units whose lines feed fixed
// primary sources CASC_BASE, CASC_BASE-CASC_STEP, ...
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int AUX_COUNT = 2,
    parameter int CASC_BASE = 30,
    parameter int CASC_STEP = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [31:0] src_main,
    input  logic [31:0] src_aux1,
    input  logic [31:0] src_aux2,
    output logic        irq_out,
    output logic [7:0]  irq_vec
);
    localparam int NUNIT = 1 + AUX_COUNT;

    logic [1:0]         unit_sel;
    irqc_reg_e          reg_sel;
    logic [31:0]        aux_src   [2];
    logic [31:0]        lines     [NUNIT];
    logic [31:0]        stat      [NUNIT];
    logic [31:0]        enab      [NUNIT];
    logic [31:0]        mskd      [NUNIT];
    logic [7:0]         vecs      [NUNIT];
    logic [31:0]        casc_acc  [NUNIT];
    logic [NUNIT-1:0]   u_irq;
    logic [31:0]        prim_lines;
    logic [31:0]        prim_stat, prim_en, prim_masked;

    assign unit_sel   = reg_addr[3:2];
    assign reg_sel    = irqc_reg_e'(reg_addr[1:0]);
    assign aux_src[0] = src_aux1;
    assign aux_src[1] = src_aux2;

    assign casc_acc[0] = '0;
    assign prim_lines  = src_main | casc_acc[NUNIT-1];

    for (genvar k = 0; k < NUNIT; k++) begin : g_unit
        if (k == 0) begin : g_prim
            assign lines[k] = prim_lines;
        end else begin : g_aux
            assign lines[k]    = aux_src[k-1];
            assign casc_acc[k] = casc_acc[k-1]
                               | (32'(u_irq[k]) << (CASC_BASE - CASC_STEP*(k-1)));
        end

        irqc_unit #(.NSRC(IRQC_NSRC), .VW(IRQC_VW)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .stat_wr (wr_en && (unit_sel == 2'(k)) && (reg_sel == REG_STATUS)),
            .en_wr   (wr_en && (unit_sel == 2'(k)) && (reg_sel == REG_ENABLE)),
            .wdata   (wr_data),
            .lines   (lines[k]),
            .stat_q  (stat[k]),
            .en_q    (enab[k]),
            .masked  (mskd[k]),
            .vec     (vecs[k]),
            .irq     (u_irq[k])
        );
    end

    assign prim_stat   = stat[0];
    assign prim_en     = enab[0];
    assign prim_masked = mskd[0];
    assign irq_out     = u_irq[0];
    assign irq_vec     = vecs[0];

    always_comb begin
        rd_data = '0;
        if (32'(unit_sel) < NUNIT) begin
            unique case (reg_sel)
                REG_STATUS: rd_data = stat[unit_sel];
                REG_ENABLE: rd_data = enab[unit_sel];
                REG_MASKED: rd_data = mskd[unit_sel];
                REG_VECTOR: rd_data = {24'b0, vecs[unit_sel]};
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  reg_addr,
    input logic [31:0] wr_data,
    input logic [31:0] prim_lines,
    input logic [31:0] prim_stat,
    input logic [31:0] prim_masked,
    input logic        irq_out,
    input logic [7:0]  irq_vec
);
    logic [31:0] rev_lines;
    logic        stat_wr;

    always_comb begin
        for (int i = 0; i < 32; i++) rev_lines[31-i] = prim_lines[i];
    end
    assign stat_wr = wr_en && (reg_addr == 4'h0);

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((prim_stat & $past(rev_lines)) == $past(rev_lines)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((prim_stat & $past(prim_stat)) == $past(prim_stat)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((prim_stat & $past(wr_data) & ~$past(rev_lines)) == 32'h0));

    assert_vec_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec == 8'hFF) |-> (prim_masked == 32'h0));

    assert_vec_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec != 8'hFF) |-> (prim_masked[7'd31 - {2'b0, irq_vec[4:0]}]
            && ((prim_masked >> (7'd32 - {2'b0, irq_vec[4:0]})) == 32'h0)));

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_masked != 32'h0) |=> irq_out);

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_masked == 32'h0) |=> !irq_out);
endmodule

bind irqc_cascade irqc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .reg_addr    (reg_addr),
    .wr_data     (wr_data),
    .prim_lines  (prim_lines),
    .prim_stat   (prim_stat),
    .prim_masked (prim_masked),
    .irq_out     (irq_out),
    .irq_vec     (irq_vec)
);

// File: tb/irqc_cascade_tb.sv
module irqc_cascade_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] src_main = '0, src_aux1 = '0, src_aux2 = '0;
    logic        irq_out;
    logic [7:0]  irq_vec;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_cascade u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .src_main(src_main),
        .src_aux1(src_aux1), .src_aux2(src_aux2),
        .irq_out(irq_out), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); check("R1 status", d, 32'h0);
        rd(4'h1, d); check("R1 enable", d, 32'h0);
        rd(4'h3, d); check("R1 vector reg", d, 32'hFF);
        check("R1 irq_out", 32'(irq_out), 32'h0);
        check("R1 irq_vec", 32'(irq_vec), 32'hFF);
    endtask

    task automatic t_sticky;
        logic [31:0] d;
        src_main[5] = 1'b1; @(negedge clk); src_main[5] = 1'b0;
        rd(4'h0, d); check("R2 source5 to bit26", d, 32'h0400_0000);
        cycles(3);
        rd(4'h0, d); check("R2 sticky after fall", d, 32'h0400_0000);
        wr(4'h0, 32'h0400_0000);
        rd(4'h0, d); check("R8 clear visible next cycle", d, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        src_main[0] = 1'b1; src_main[31] = 1'b1; @(negedge clk);
        src_main = '0;
        rd(4'h0, d); check("R2 sources 0 and 31", d, 32'h8000_0001);
        wr(4'h0, 32'h0000_0001);
        rd(4'h0, d); check("R3 zeros untouched", d, 32'h8000_0000);
        src_main[3] = 1'b1; @(negedge clk);
        wr(4'h0, 32'h1000_0000);
        rd(4'h0, d); check("R3 clear with live level", d, 32'h9000_0000);
        src_main[3] = 1'b0;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R3 clear all", d, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        src_main[2] = 1'b1; src_main[7] = 1'b1; @(negedge clk); src_main = '0;
        wr(4'h1, 32'h2000_0000);
        rd(4'h1, d); check("R4 enable readback", d, 32'h2000_0000);
        rd(4'h2, d); check("R4 masked view", d, 32'h2000_0000);
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h3, 32'h0000_0000);
        rd(4'h2, d); check("R4 masked write ignored", d, 32'h2000_0000);
        rd(4'h1, d); check("R4 enable untouched", d, 32'h2000_0000);
        rd(4'h0, d); check("R4 status untouched", d, 32'h2100_0000);
    endtask

    task automatic t_vector;
        logic [31:0] d;
        wr(4'h1, 32'h2100_0000);
        rd(4'h3, d); check("R5 lowest of 2 and 7", d, 32'd2);
        check("R5 port vector", 32'(irq_vec), 32'd2);
        wr(4'h0, 32'h2000_0000);
        rd(4'h3, d); check("R5 after clearing 2", d, 32'd7);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h3, d); check("R5 none pending", d, 32'hFF);
        wr(4'h1, 32'hFFFF_FFFF);
        src_main[0] = 1'b1; src_main[31] = 1'b1; @(negedge clk); src_main = '0;
        check("R5 source 0 wins", 32'(irq_vec), 32'd0);
        wr(4'h0, 32'h8000_0000);
        check("R5 source 31 alone", 32'(irq_vec), 32'd31);
        wr(4'h0, 32'hFFFF_FFFF);
        cycles(1);
    endtask

    task automatic t_irq;
        check("R6 idle low", 32'(irq_out), 32'h0);
        src_main[9] = 1'b1; @(negedge clk); src_main = '0;
        check("R6 low one edge after latch", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R6 raised", 32'(irq_out), 32'h1);
        wr(4'h0, 32'h0040_0000);
        check("R6 still high at clear edge", 32'(irq_out), 32'h1);
        @(negedge clk);
        check("R6 dropped after clear", 32'(irq_out), 32'h0);
        src_main[9] = 1'b1; @(negedge clk); src_main = '0;
        @(negedge clk);
        check("R6 raised again", 32'(irq_out), 32'h1);
        wr(4'h1, 32'h0);
        @(negedge clk);
        check("R6 dropped after mask", 32'(irq_out), 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
    endtask

    task automatic t_cascade;
        logic [31:0] d;
        wr(4'h1, 32'h0000_000A);
        wr(4'h5, 32'h0800_0000);
        src_aux1[4] = 1'b1; @(negedge clk); src_aux1 = '0;
        cycles(4);
        rd(4'h0, d); check("R7 aux1 into bit 1", d, 32'h0000_0002);
        check("R7 irq from aux1", 32'(irq_out), 32'h1);
        check("R7 vector 30", 32'(irq_vec), 32'd30);
        wr(4'h9, 32'h8000_0000);
        src_aux2[0] = 1'b1; @(negedge clk); src_aux2 = '0;
        cycles(4);
        rd(4'h0, d); check("R7 aux2 into bit 3", d, 32'h0000_000A);
        check("R7 vector prefers 28", 32'(irq_vec), 32'd28);
        wr(4'h0, 32'h0000_0008);
        rd(4'h0, d); check("R7 level holds bit 3", d, 32'h0000_000A);
        wr(4'h8, 32'h8000_0000);
        cycles(2);
        wr(4'h0, 32'h0000_0008);
        rd(4'h0, d); check("R7 bit 3 clears after aux2", d, 32'h0000_0002);
    endtask

    task automatic t_units;
        logic [31:0] d;
        rd(4'hC, d); check("R9 unit 3 status zero", d, 32'h0);
        rd(4'hD, d); check("R9 unit 3 enable zero", d, 32'h0);
        rd(4'h4, d); check("R9 aux1 status", d, 32'h0800_0000);
        wr(4'h5, 32'h1234_5678);
        rd(4'h5, d); check("R9 aux1 enable written", d, 32'h1234_5678);
        rd(4'h1, d); check("R9 primary enable kept", d, 32'h0000_000A);
        rd(4'h9, d); check("R9 aux2 enable kept", d, 32'h8000_0000);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_w1c();
        t_mask();
        t_vector();
        t_irq();
        t_cascade();
        t_units();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule